// File: doc/BRIEF.md
# Queue Status Interrupt Controller

This block watches four occupancy flags (empty, nearly empty, nearly full, full) for each of 32 hardware queues. Software picks one flag and one edge direction per queue through a 3-bit source code. When that edge is seen, the block latches a per-queue pending bit, and it merges the pending bits into one interrupt line. A simple register port gives access to four source-select words, a 32-bit enable mask and a write-one-to-clear pending word.

A global clear policy runs as a two-state machine. The two states are `MODE_ANY_CLEAR` (the reset state) and `MODE_COND_CLEAR`. The state register is loaded from bit 3 of select word 0 on every write to address 0. Writing 1 there takes the transition ANY→COND, and writing 0 takes COND→ANY; any other write leaves the state as it is. In `MODE_ANY_CLEAR` the enable mask gates the setting of pending bits, a write of 1 always clears a bit, and the interrupt is the OR of all pending bits. In `MODE_COND_CLEAR` pending bits set whatever the enable mask holds, a write of 1 clears a bit only once its condition has gone away, and the interrupt is the OR of pending AND enable. Each pending bit has two states, idle and pending. It goes idle→pending on a qualifying edge and pending→idle on a permitted clear.

Top module: `qsi_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, every queue uses code 000, the clear state is `MODE_ANY_CLEAR`, and `irq` is 0.
- R2: Address n (0..3) holds the codes for queues 8n..8n+7. Queue 8n+k sits in bits 4k+2..4k. Bit 3 of address 0 is the clear-mode bit (0 = ANY, 1 = COND). All other bits 4k+3 read 0. Address 4 is the enable mask and address 5 is the pending word (bit q = queue q). Other addresses read 0.
- R3: Input `q_flags[4q+f]` is flag f of queue q (f: 0 empty, 1 nearly empty, 2 nearly full, 3 full). Code bits [1:0] pick f. Code bit 2 = 0 selects a 0→1 edge and bit 2 = 1 selects a 1→0 edge. The edge compares a flag with its value one clock earlier, and the pending bit reads 1 after the clock edge that samples the change.
- R4: In `MODE_ANY_CLEAR` a selected edge does not set a pending bit whose enable bit is 0.
- R5: In `MODE_ANY_CLEAR` writing 1 to a pending bit clears it even while the condition still holds. `irq` is 1 whenever any pending bit is 1, whatever the enable mask holds.
- R6: In `MODE_COND_CLEAR` a selected edge sets the pending bit whatever its enable bit holds. `irq` is 1 only when some bit is both pending and enabled.
- R7: In `MODE_COND_CLEAR` a write of 1 clears a bit only when the level matching its code no longer holds. For a 0→1 code the flag must be 0, and for a 1→0 code the flag must be 1. Otherwise the bit stays set.
- R8: Taking the COND→ANY transition with a pending bit whose enable is 0 raises `irq` right after the write.
- R9: If a set and a write-one clear hit the same bit in the same cycle, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| q_flags | input | 128 | Four status flags per queue, queue q at bits 4q+3..4q |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets three corner cases. The first is a clear attempt while a going-true or going-false condition still holds in COND mode: a design that ignores the level, or checks the wrong polarity for going-false codes, would drop the bit early or keep it forever. The second is the COND→ANY transition with a disabled pending bit: a design that registers the output or keeps masking it would leave `irq` low. The third is a set and a clear in the same cycle: a design that lets the clear win would lose an interrupt. The bench also checks packing at the far ends of the select words (queue 31 and the reserved bits), since an off-by-one slot mapping would send edges to the wrong queue.

// File: rtl/qsi_pkg.sv
package qsi_pkg;
    localparam int FLAG_W   = 4;   // flags per queue
    localparam int CODE_W   = 3;   // source code width
    localparam int SLOT_W   = 4;   // field pitch inside a select word
    localparam int MODE_BIT = 3;   // clear-mode bit in select word 0

    typedef enum logic {
        MODE_ANY_CLEAR  = 1'b0,
        MODE_COND_CLEAR = 1'b1
    } clr_mode_e;
endpackage

// File: rtl/qsi_cfg_regs.sv
module qsi_cfg_regs
    import qsi_pkg::*;
#(
    parameter int NUM_Q     = 32,
    parameter int Q_PER_REG = 8,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [NUM_Q*CODE_W-1:0] codes_o,
    output logic [NUM_Q-1:0]        en_o,
    output clr_mode_e               mode_o,
    output logic                    clr_req_o,
    output logic [NUM_Q-1:0]        clr_mask_o
);
    localparam int NUM_SEL = NUM_Q / Q_PER_REG;
    localparam int ADDR_EN = NUM_SEL;
    localparam int ADDR_ST = NUM_SEL + 1;

    clr_mode_e          mode_q, mode_d;
    logic [NUM_Q-1:0]   en_q;
    logic               wr_sel0;

    assign wr_sel0 = wr_en && (wr_addr == '0);

    // clear-policy state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_ANY_CLEAR;
        else        mode_q <= mode_d;
    end

    // clear-policy transitions
    always_comb begin
        mode_d = mode_q;
        if (wr_sel0) begin
            unique case (wr_data[MODE_BIT])
                1'b0:    mode_d = MODE_ANY_CLEAR;
                1'b1:    mode_d = MODE_COND_CLEAR;
                default: mode_d = mode_q;
            endcase
        end
    end

    // per-queue source codes
    for (genvar q = 0; q < NUM_Q; q++) begin : g_code
        localparam int REG  = q / Q_PER_REG;
        localparam int SLOT = q % Q_PER_REG;
        logic [CODE_W-1:0] code_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                code_q <= '0;
            else if (wr_en && wr_addr == ADDR_W'(REG))
                code_q <= wr_data[SLOT*SLOT_W +: CODE_W];
        end
        assign codes_o[q*CODE_W +: CODE_W] = code_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr_en && wr_addr == ADDR_W'(ADDR_EN))
            en_q <= wr_data[NUM_Q-1:0];
    end

    assign en_o       = en_q;
    assign mode_o     = mode_q;
    assign clr_req_o  = wr_en && (wr_addr == ADDR_W'(ADDR_ST));
    assign clr_mask_o = wr_data[NUM_Q-1:0];
endmodule

// File: rtl/qsi_edge_detect.sv
module qsi_edge_detect
    import qsi_pkg::*;
#(
    parameter int NUM_Q = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_Q*FLAG_W-1:0] flags_i,
    input  logic [NUM_Q*CODE_W-1:0] codes_i,
    output logic [NUM_Q-1:0]        ev_o,
    output logic [NUM_Q-1:0]        level_o
);
    logic [NUM_Q*FLAG_W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= flags_i;
    end

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        logic [CODE_W-1:0] code;
        logic [FLAG_W-1:0] now_n, old_n;
        logic              now_b, old_b;
        assign code  = codes_i[q*CODE_W +: CODE_W];
        assign now_n = flags_i[q*FLAG_W +: FLAG_W];
        assign old_n = prev_q[q*FLAG_W +: FLAG_W];
        assign now_b = now_n[code[1:0]];
        assign old_b = old_n[code[1:0]];
        // code[2]: 0 = going true, 1 = going false
        assign ev_o[q]    = code[2] ? (old_b & ~now_b) : (now_b & ~old_b);
        assign level_o[q] = code[2] ? ~now_b : now_b;
    end
endmodule

// File: rtl/qsi_status_bank.sv
module qsi_status_bank
    import qsi_pkg::*;
#(
    parameter int NUM_Q = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_Q-1:0] ev_i,
    input  logic [NUM_Q-1:0] level_i,
    input  logic [NUM_Q-1:0] en_i,
    input  clr_mode_e        mode_i,
    input  logic             clr_req_i,
    input  logic [NUM_Q-1:0] clr_mask_i,
    output logic [NUM_Q-1:0] status_o,
    output logic             irq_o
);
    logic [NUM_Q-1:0] status_q, status_d, set_v, clr_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    always_comb begin
        unique case (mode_i)
            MODE_ANY_CLEAR: begin
                set_v = ev_i & en_i;
                clr_v = clr_req_i ? clr_mask_i : '0;
            end
            MODE_COND_CLEAR: begin
                set_v = ev_i;
                clr_v = clr_req_i ? (clr_mask_i & ~level_i) : '0;
            end
            default: begin
                set_v = '0;
                clr_v = '0;
            end
        endcase
        // set has priority over clear
        status_d = set_v | (status_q & ~clr_v);
    end

    always_comb begin
        unique case (mode_i)
            MODE_ANY_CLEAR:  irq_o = |status_q;
            MODE_COND_CLEAR: irq_o = |(status_q & en_i);
            default:         irq_o = 1'b0;
        endcase
    end

    assign status_o = status_q;

    // a bit only becomes pending after an edge on its source
    assert_set_needs_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(ev_i)) == '0));

    // gated setting in ANY mode
    assert_gate_any_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_ANY_CLEAR) |=>
            ((status_q & ~$past(en_i) & ~$past(status_q)) == '0));

    // unconditional clear in ANY mode when no edge competes
    assert_w1c_any_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_ANY_CLEAR && clr_req_i) |=>
            ((status_q & $past(clr_mask_i & ~(ev_i & en_i))) == '0));

    // held condition blocks the clear in COND mode
    assert_cond_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_COND_CLEAR && clr_req_i) |=>
            ((status_q & $past(clr_mask_i & status_q & level_i))
                == $past(clr_mask_i & status_q & level_i)));

    // set beats clear
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req_i |=> ((status_q & $past(ev_i & en_i)) == $past(ev_i & en_i)));
endmodule

// File: rtl/qsi_irq_ctrl.sv
module qsi_irq_ctrl
    import qsi_pkg::*;
#(
    parameter int NUM_Q     = 32,
    parameter int Q_PER_REG = 8,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [DATA_W-1:0]       rd_data,
    input  logic [NUM_Q*FLAG_W-1:0] q_flags,
    output logic                    irq
);
    localparam int NUM_SEL = NUM_Q / Q_PER_REG;
    localparam int SEL_AW  = $clog2(NUM_SEL);
    localparam int ADDR_EN = NUM_SEL;
    localparam int ADDR_ST = NUM_SEL + 1;

    logic [NUM_Q*CODE_W-1:0] codes;
    logic [NUM_Q-1:0]        en, ev, level, clr_mask, status;
    logic                    clr_req;
    clr_mode_e               mode;
    logic [DATA_W-1:0]       sel_word [NUM_SEL];

    qsi_cfg_regs #(
        .NUM_Q(NUM_Q), .Q_PER_REG(Q_PER_REG), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) i_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .codes_o(codes), .en_o(en), .mode_o(mode),
        .clr_req_o(clr_req), .clr_mask_o(clr_mask)
    );

    qsi_edge_detect #(.NUM_Q(NUM_Q)) i_edge (
        .clk(clk), .rst_n(rst_n), .flags_i(q_flags), .codes_i(codes),
        .ev_o(ev), .level_o(level)
    );

    qsi_status_bank #(.NUM_Q(NUM_Q)) i_status (
        .clk(clk), .rst_n(rst_n), .ev_i(ev), .level_i(level), .en_i(en),
        .mode_i(mode), .clr_req_i(clr_req), .clr_mask_i(clr_mask),
        .status_o(status), .irq_o(irq)
    );

    // read-back words for the select registers
    for (genvar r = 0; r < NUM_SEL; r++) begin : g_word
        for (genvar k = 0; k < Q_PER_REG; k++) begin : g_slot
            assign sel_word[r][k*SLOT_W +: CODE_W] =
                codes[(r*Q_PER_REG + k)*CODE_W +: CODE_W];
            if (r == 0 && k == 0) begin : g_mode
                assign sel_word[r][MODE_BIT] = (mode == MODE_COND_CLEAR);
            end else begin : g_rsvd
                assign sel_word[r][k*SLOT_W + CODE_W] = 1'b0;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr < ADDR_W'(NUM_SEL))
            rd_data = sel_word[rd_addr[SEL_AW-1:0]];
        else if (rd_addr == ADDR_W'(ADDR_EN))
            rd_data = DATA_W'(en);
        else if (rd_addr == ADDR_W'(ADDR_ST))
            rd_data = DATA_W'(status);
    end

    // ANY mode: any pending bit drives the line
    assert_any_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ANY_CLEAR && status != '0) |-> irq);

    // COND mode: disabled pending bits stay silent
    assert_cond_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_COND_CLEAR && (status & en) == '0) |-> !irq);
endmodule

// File: tb/test_qsi_irq_ctrl.sv
module test_qsi_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 27;
    // {we, addr[2:0], wdata[31:0], q10 flags[3:0], exp pending, exp irq, req[3:0]}
    localparam logic [45:0] VEC [NV] = '{
        {1'b1, 3'd4, 32'h0000_0400, 4'b0000, 1'b0, 1'b0, 4'd4}, // R4 enable q10
        {1'b0, 3'd0, 32'h0,         4'b0001, 1'b1, 1'b1, 4'd3}, // R3 empty rises
        {1'b1, 3'd5, 32'h0000_0400, 4'b0001, 1'b0, 1'b0, 4'd5}, // R5 clear while held
        {1'b0, 3'd0, 32'h0,         4'b0000, 1'b0, 1'b0, 4'd3}, // R3 wrong direction
        {1'b1, 3'd1, 32'h0000_0300, 4'b0000, 1'b0, 1'b0, 4'd2}, // R2 q10 = full rise
        {1'b0, 3'd0, 32'h0,         4'b1000, 1'b1, 1'b1, 4'd3}, // R3 full rises
        {1'b1, 3'd4, 32'h0,         4'b1000, 1'b1, 1'b1, 4'd5}, // R5 irq ignores mask
        {1'b1, 3'd5, 32'h0000_0400, 4'b1000, 1'b0, 1'b0, 4'd5},
        {1'b0, 3'd0, 32'h0,         4'b0000, 1'b0, 1'b0, 4'd4},
        {1'b0, 3'd0, 32'h0,         4'b1000, 1'b0, 1'b0, 4'd4}, // R4 disabled edge
        {1'b1, 3'd0, 32'h0000_0008, 4'b1000, 1'b0, 1'b0, 4'd6}, // enter COND
        {1'b0, 3'd0, 32'h0,         4'b0000, 1'b0, 1'b0, 4'd6},
        {1'b0, 3'd0, 32'h0,         4'b1000, 1'b1, 1'b0, 4'd6}, // R6 set, masked
        {1'b1, 3'd5, 32'h0000_0400, 4'b1000, 1'b1, 1'b0, 4'd7}, // R7 held, no clear
        {1'b1, 3'd4, 32'h0000_0400, 4'b1000, 1'b1, 1'b1, 4'd6}, // R6 unmask
        {1'b0, 3'd0, 32'h0,         4'b0000, 1'b1, 1'b1, 4'd3},
        {1'b1, 3'd5, 32'h0000_0400, 4'b0000, 1'b0, 1'b0, 4'd7}, // R7 gone, clears
        {1'b1, 3'd1, 32'h0000_0500, 4'b0010, 1'b0, 1'b0, 4'd3}, // code near-empty fall
        {1'b0, 3'd0, 32'h0,         4'b0000, 1'b1, 1'b1, 4'd3}, // R3 falling edge
        {1'b1, 3'd5, 32'h0000_0400, 4'b0010, 1'b0, 1'b0, 4'd7}, // R7 flag back to 1
        {1'b0, 3'd0, 32'h0,         4'b0000, 1'b1, 1'b1, 4'd3},
        {1'b1, 3'd5, 32'h0000_0400, 4'b0000, 1'b1, 1'b1, 4'd7}, // R7 flag still 0
        {1'b1, 3'd4, 32'h0,         4'b0000, 1'b1, 1'b0, 4'd6},
        {1'b1, 3'd0, 32'h0,         4'b0000, 1'b1, 1'b1, 4'd8}, // R8 back to ANY
        {1'b1, 3'd5, 32'h0000_0400, 4'b0000, 1'b0, 1'b0, 4'd5},
        {1'b1, 3'd4, 32'h0000_0400, 4'b0010, 1'b0, 1'b0, 4'd9},
        {1'b1, 3'd5, 32'h0000_0400, 4'b0000, 1'b1, 1'b1, 4'd9}  // R9 set beats clear
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [2:0]   rd_addr = '0;
    logic [31:0]  rd_data;
    logic [127:0] q_flags = '0;
    logic         irq;
    int           n_checks = 0;
    int           n_errors = 0;
    bit           done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qsi_irq_ctrl i_qsi_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .q_flags(q_flags), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_reg(input string tag, input logic [2:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        for (int a = 0; a < 6; a++) check_reg("R1 reset register", 3'(a), 32'h0);
        check("R1 reset irq", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq after release", {31'b0, irq}, 32'h0);

        // vector walk on queue 10 (flags at bits 43:40)
        rd_addr = 3'd5;
        for (int i = 0; i < NV; i++) begin
            wr_en   = VEC[i][45];
            wr_addr = VEC[i][44:42];
            wr_data = VEC[i][41:10];
            q_flags[40 +: 4] = VEC[i][9:6];
            @(negedge clk);
            check($sformatf("R%0d vector %0d pending", VEC[i][3:0], i),
                  rd_data, {21'b0, VEC[i][5], 10'b0});
            check($sformatf("R%0d vector %0d irq", VEC[i][3:0], i),
                  {31'b0, irq}, {31'b0, VEC[i][4]});
        end
        wr_en = 1'b0;
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd4, 32'h0);
        wr(3'd1, 32'h0);
        check_reg("R5 cleanup pending", 3'd5, 32'h0);

        // R2: packing and reserved bits
        wr(3'd2, 32'hFFFF_FFFF);
        check_reg("R2 word 2 reserved bits", 3'd2, 32'h7777_7777);
        wr(3'd0, 32'hFFFF_FFFF);
        check_reg("R2 word 0 with mode bit", 3'd0, 32'h7777_777F);
        check_reg("R2 unmapped address", 3'd6, 32'h0);
        wr(3'd0, 32'h0);
        wr(3'd2, 32'h0);
        check_reg("R2 word 0 restored", 3'd0, 32'h0);

        // R3: queue 31, full going true, top slot of word 3
        wr(3'd3, 32'h3000_0000);
        check_reg("R2 word 3 top slot", 3'd3, 32'h3000_0000);
        wr(3'd4, 32'h8000_0000);
        @(negedge clk);
        q_flags[124 +: 4] = 4'b0100;   // nearly full only: not selected
        @(negedge clk);
        check_reg("R3 q31 unselected flag", 3'd5, 32'h0);
        q_flags[124 +: 4] = 4'b1100;
        @(negedge clk);
        check_reg("R3 q31 full rises", 3'd5, 32'h8000_0000);
        check("R3 q31 irq", {31'b0, irq}, 32'h1);

        // R9 in ANY mode on queue 31: edge and clear in one cycle
        wr(3'd5, 32'h8000_0000);
        check_reg("R5 q31 cleared", 3'd5, 32'h0);
        q_flags[124 +: 4] = 4'b0000;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd5; wr_data = 32'h8000_0000;
        q_flags[124 +: 4] = 4'b1000;
        @(negedge clk);
        wr_en = 1'b0;
        check_reg("R9 q31 set wins", 3'd5, 32'h8000_0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule